// File: doc/BRIEF.md
# Pipelined SRAM Read Output and Deselect Stage

This block sits on the output side of a pipelined synchronous SRAM. Each clock it captures a command (read, write or deselect) into an input register. A read command fetches one word from the storage array during the following cycle. That word is registered into an output register and driven onto the data bus after the next rising edge, so a read captured on one edge appears after the next.

The block works out when the bus driver turns on and off. A static mode input picks between two deselect behaviours. In dual-cycle mode (mode input high), a non-read command moves through the same two register stages as a read. The driver therefore turns off one full cycle after the command is captured. In single-cycle mode (mode input low, the default tie-off), the driver turns off as soon as a non-read command sits in the input register. This is one stage earlier than read data, and it frees the shared I/O bus sooner. Write commands use the same path as a deselect, so the driver is never on while write data may be on the common bus. An asynchronous output enable cuts the driver at once, whatever the pipeline holds.

The data bus is modelled as a value plus a drive-enable flag. The value reads as zero whenever the flag is low.

Top module: `sram_read_deselect`

## Requirements
- R1: While reset is asserted and after it is released, with no read command yet captured, `dq_drive` is 0 and `dq_out` is 0.
- R2: Command encoding on `cmd_i` is 2'b00 deselect, 2'b01 read, 2'b10 write and 2'b11 no-op (treated as deselect). A read captured on rising edge k makes `dq_out` equal to the `rd_data` value present at edge k+1, driven with `dq_drive` = 1 from edge k+1 until edge k+2, when `oe_i` is 1.
- R3: Reads captured on consecutive edges stream one word per cycle, each word held for exactly one cycle.
- R4: With `mode_dcd` = 1, a non-read command captured on edge k leaves the driver as set by the previous command until edge k+1, and the driver is off from edge k+1.
- R5: With `mode_dcd` = 0, a non-read command captured on edge k turns the driver off from edge k. A read directly before it is therefore not driven.
- R6: A write command (2'b10) turns the driver off with the same timing as a deselect in both modes.
- R7: While `oe_i` is 0, `dq_drive` is 0 and `dq_out` is 0 with no clock edge needed. When `oe_i` returns to 1, the output shows the current pipeline state within the same cycle.
- R8: Whenever `dq_drive` is 0, `dq_out` is all zeros.
- R9: The no-op code 2'b11 behaves exactly like deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dcd | input | 1 | Static deselect mode: 1 dual-cycle, 0 single-cycle (default) |
| cmd_i | input | 2 | Command sampled on each rising edge |
| rd_data | input | 36 | Word from the storage array, valid in the cycle after a read is captured |
| oe_i | input | 1 | Asynchronous output enable, active high |
| dq_out | output | 36 | Data bus value, zero when not driven |
| dq_drive | output | 1 | Bus driver enable |

## Verification
The hardest case to reach is the exact edge at which the driver turns off when a non-read command directly follows a read. In single-cycle mode that read is never driven. In dual-cycle mode it is driven for one cycle. The stimulus places reads, writes, deselects and no-ops back to back in both modes, and compares a queue-based reference against the outputs every cycle. Output enable is dropped and restored in the middle of a cycle to check that it gates the bus without a clock edge.

// File: rtl/sram_out_pkg.sv
package sram_out_pkg;
   typedef enum logic [1:0] {
      CMD_DESEL = 2'b00,
      CMD_READ  = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_NOP   = 2'b11
   } cmd_e;

   function automatic logic cmd_is_read(input logic [1:0] c);
      return c == CMD_READ;
   endfunction
endpackage

// File: rtl/rdo_cmd_reg.sv
module rdo_cmd_reg
   import sram_out_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cmd_i,
   output logic       s1_rd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_rd <= 1'b0;
      else        s1_rd <= cmd_is_read(cmd_i);
   end
endmodule

// File: rtl/rdo_data_stage.sv
module rdo_data_stage #(
   parameter int DATA_W = 36,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s1_rd,
   input  logic [DATA_W-1:0] rd_data,
   output logic              s2_rd,
   output logic [DATA_W-1:0] data_q
);
   localparam int LANE_W = DATA_W / LANES;

   if (LANES < 1 || (DATA_W % LANES) != 0) begin : g_bad_split
      $error("rdo_data_stage: DATA_W must split evenly into LANES");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s2_rd <= 1'b0;
      else        s2_rd <= s1_rd;
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            data_q[ln*LANE_W +: LANE_W] <= '0;
         else if (s1_rd)
            data_q[ln*LANE_W +: LANE_W] <= rd_data[ln*LANE_W +: LANE_W];
      end
   end

   AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      s1_rd |=> (s2_rd && data_q == $past(rd_data)));  // R2
endmodule

// File: rtl/rdo_drive_ctrl.sv
module rdo_drive_ctrl (
   input  logic mode_dcd,
   input  logic s1_rd,
   input  logic s2_rd,
   input  logic oe_i,
   output logic drive_o
);
   logic pipe_on;

   always_comb begin
      if (mode_dcd) pipe_on = s2_rd;
      else          pipe_on = s2_rd & s1_rd;
      drive_o = pipe_on & oe_i;
   end
endmodule

// File: rtl/sram_read_deselect.sv
module sram_read_deselect
   import sram_out_pkg::*;
#(
   parameter int DATA_W = 36,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_dcd,
   input  logic [1:0]        cmd_i,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              oe_i,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_drive
);
   if (DATA_W < 1) begin : g_bad_width
      $error("sram_read_deselect: DATA_W must be positive");
   end

   logic              s1_rd;
   logic              s2_rd;
   logic [DATA_W-1:0] data_q;
   logic              drive_int;

   rdo_cmd_reg u_cmd (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd_i (cmd_i),
      .s1_rd (s1_rd)
   );

   rdo_data_stage #(.DATA_W(DATA_W), .LANES(LANES)) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .s1_rd   (s1_rd),
      .rd_data (rd_data),
      .s2_rd   (s2_rd),
      .data_q  (data_q)
   );

   rdo_drive_ctrl u_drv (
      .mode_dcd (mode_dcd),
      .s1_rd    (s1_rd),
      .s2_rd    (s2_rd),
      .oe_i     (oe_i),
      .drive_o  (drive_int)
   );

   assign dq_drive = drive_int;
   assign dq_out   = drive_int ? data_q : '0;

   AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_i |-> !dq_drive);  // R7
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_drive |-> dq_out == '0);  // R8
   AST_SCD_EARLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_dcd && $past(cmd_i) != CMD_READ) |-> !dq_drive);  // R5
   AST_SCD_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_dcd && $past(cmd_i) == CMD_WRITE) |-> !dq_drive);  // R6
   AST_DCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_dcd && s2_rd && oe_i) |-> dq_drive);  // R4
endmodule

// File: tb/sram_read_deselect_bench.sv
module sram_read_deselect_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_dcd = 1'b0;
   logic [1:0]    cmd_i = 2'b00;
   logic [DW-1:0] rd_data = '0;
   logic          oe_i = 1'b1;
   logic [DW-1:0] dq_out;
   logic          dq_drive;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state: history of read flags, newest first
   bit            hist[$];
   logic [DW-1:0] ref_word = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_read_deselect u_sram_read_deselect (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_dcd (mode_dcd),
      .cmd_i    (cmd_i),
      .rd_data  (rd_data),
      .oe_i     (oe_i),
      .dq_out   (dq_out),
      .dq_drive (dq_drive)
   );

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic bit exp_drive();
      bit newest = hist[0];
      bit older  = hist[1];
      if (!oe_i) return 1'b0;
      if (mode_dcd) return older;
      return older && newest;
   endfunction

   task automatic compare(input string tag);
      bit d = exp_drive();
      check(tag, {35'd0, dq_drive}, {35'd0, d});
      check(d ? tag : "R8", dq_out, d ? ref_word : '0);
   endtask

   // one cycle: drive inputs, clock, update model, compare
   task automatic step(input logic [1:0] c, input string tag);
      @(negedge clk);
      cmd_i = c;
      rd_data = {$urandom(), $urandom()};
      @(posedge clk);
      if (hist[0]) ref_word = rd_data;
      hist.push_front(c == 2'b01);
      void'(hist.pop_back());
      #2;
      compare(tag);
   endtask

   task automatic oe_blip(input string tag);
      #1 oe_i = 1'b0;
      #1;
      check(tag, {35'd0, dq_drive}, 36'd0);
      check(tag, dq_out, '0);
      oe_i = 1'b1;
      #1;
      compare(tag);
   endtask

   task automatic reset_all(input logic m);
      @(negedge clk);
      rst_n = 1'b0;
      mode_dcd = m;
      cmd_i = 2'b00;
      hist = '{0, 0};
      ref_word = '0;
      @(negedge clk);
      check("R1", {34'd0, dq_drive, 1'b0}, 36'd0);
      check("R1", dq_out, '0);
      rst_n = 1'b1;
   endtask

   initial begin
      reset_all(1'b0);
      // single-cycle mode
      step(2'b00, "R1");
      step(2'b01, "R2");
      step(2'b01, "R2");
      step(2'b01, "R3");
      step(2'b01, "R3");
      oe_blip("R7");
      step(2'b00, "R5");
      step(2'b00, "R5");
      step(2'b01, "R2");
      step(2'b01, "R3");
      step(2'b10, "R6");
      step(2'b01, "R6");
      step(2'b01, "R3");
      step(2'b11, "R9");
      step(2'b00, "R9");
      step(2'b01, "R5");
      step(2'b00, "R5");
      // dual-cycle mode
      reset_all(1'b1);
      step(2'b00, "R1");
      step(2'b01, "R2");
      step(2'b00, "R4");
      step(2'b00, "R4");
      step(2'b01, "R2");
      step(2'b01, "R3");
      oe_blip("R7");
      step(2'b01, "R3");
      step(2'b10, "R6");
      step(2'b10, "R6");
      step(2'b01, "R4");
      step(2'b11, "R9");
      step(2'b11, "R9");
      for (int i = 0; i < 40; i++) begin
         logic [1:0] c = 2'($urandom_range(0, 3));
         step(c, "R3");
         if (i % 7 == 3) oe_blip("R7");
      end
      reset_all(1'b0);
      for (int i = 0; i < 40; i++) begin
         logic [1:0] c = 2'($urandom_range(0, 3));
         step(c, "R5");
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule